// File: doc/BRIEF.md
# Asynchronous Bus Slave Acknowledge Generator

This block is the slave side of the handshake on an asynchronous, strobe-based data transfer bus. The current master pulls one or both of two active-low data strobes low to start a transfer. The block answers on an active-low acknowledge line. It never answers before a minimum settle time has passed, and it withdraws the answer quickly once the master lets both strobes go high again.

The strobes arrive from outside the clock domain. Each one passes through a chain of synchroniser flops before any decision is made on it. The settle time comes from a clocked counter whose length is a parameter. Address decoding is reduced to one select input. When the acknowledge is given, the block emits a single-cycle access pulse toward a small local store: a read pulse or a write pulse, chosen by a write input. If the master gives up before the settle time is over, the cycle is dropped without trace.

Top module: `ackgen_top`

## Requirements
- R1: When both strobes have been high for SYNC_STAGES+1 clock edges, `ackN` is 1.
- R2: A selected cycle starts when either strobe is low, whether that is `strobeAN` alone, `strobeBN` alone or both together.
- R3: With select active, `ackN` first reads 0 after rising edge SYNC_STAGES+ACK_DELAY+1 counted from the strobe fall (edge 7 with the defaults), and never earlier.
- R4: `ackN` stays 0 while at least one strobe remains low. It returns to 1 after rising edge SYNC_STAGES+1 counted from the moment both strobes are high (edge 3 with the defaults).
- R5: A strobe-low period that begins while `selIn` is 0 produces neither an acknowledge nor an access pulse.
- R6: The access pulse is high for exactly the first cycle in which `ackN` is 0. It appears on `localWr` when `writeIn` is 1 and on `localRd` when `writeIn` is 0, and never on both.
- R7: At most one access pulse occurs per strobe-low period, however long that period lasts.
- R8: If both strobes return high after ACK_DELAY or fewer clock cycles of being low, the cycle is abandoned: no acknowledge, no pulse, and the counter starts from zero on the next cycle. At ACK_DELAY+1 cycles of low time, the acknowledge is still given.
- R9: While `rstN` is 0, `ackN` is 1 and both access pulses are 0, including when reset arrives during an acknowledged cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobeAN | input | 1 | First data strobe from the master, active low, asynchronous |
| strobeBN | input | 1 | Second data strobe from the master, active low, asynchronous |
| selIn | input | 1 | Address match for this slave, active high |
| writeIn | input | 1 | Transfer direction: 1 means write, 0 means read |
| ackN | output | 1 | Data acknowledge to the master, active low |
| localRd | output | 1 | Single-cycle read strobe to the local store |
| localWr | output | 1 | Single-cycle write strobe to the local store |

## Verification
The assertions assume that `selIn` and `writeIn` behave like address and direction lines. They settle no later than the strobe fall and hold until both strobes are high again. Under that assumption, checking the select one cycle before the acknowledge falls is equivalent to checking it when the cycle opened. The stimulus changes select and direction only on the same falling clock edge as the strobe fall, or while both strobes are high. All strobe edges land on falling clock edges, so the synchroniser delay is an exact number of cycles and the expected acknowledge edges can be counted precisely.

// File: rtl/ackgen_pkg.sv
package ackgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } ackState_e;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic fireAccess;
    logic ackDrive;
  } ctrlStrobe_t;

endpackage

// File: rtl/ackgen_datapath.sv
module ackgen_datapath
  import ackgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DELAY   = 4,
  parameter int CNT_W       = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeAN,
  input  logic        strobeBN,
  input  logic        writeIn,
  input  ctrlStrobe_t ctrl,
  output logic        anyLow,
  output logic        cntDone,
  output logic        ackN,
  output logic        localRd,
  output logic        localWr
);

  localparam int LANES = 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

  logic [LANES-1:0] rawN;
  logic [LANES-1:0] syncedN;
  logic [CNT_W-1:0] delayCnt;

  assign rawN = {strobeBN, strobeAN};

  // one synchroniser chain per strobe lane
  for (genvar lane = 0; lane < LANES; lane++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawN[lane]};
    end
    assign syncedN[lane] = chain[SYNC_STAGES-1];
  end

  assign anyLow = ~&syncedN;

  // minimum-delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              delayCnt <= '0;
    else if (ctrl.cntClear) delayCnt <= '0;
    else if (ctrl.cntStep)  delayCnt <= delayCnt + CNT_W'(1);
  end

  assign cntDone = (delayCnt == CNT_LAST);

  // acknowledge and access pulse registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackN    <= 1'b1;
      localRd <= 1'b0;
      localWr <= 1'b0;
    end else begin
      ackN    <= ~ctrl.ackDrive;
      localRd <= ctrl.fireAccess & ~writeIn;
      localWr <= ctrl.fireAccess &  writeIn;
    end
  end

endmodule

// File: rtl/ackgen_control.sv
module ackgen_control
  import ackgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyLow,
  input  logic        cntDone,
  input  logic        selIn,
  output ctrlStrobe_t ctrl
);

  ackState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (anyLow) stateNext = selIn ? ST_WAIT : ST_SKIP;
      ST_WAIT: begin
        if (!anyLow)      stateNext = ST_IDLE;
        else if (cntDone) stateNext = ST_ACK;
      end
      ST_ACK:  if (!anyLow) stateNext = ST_IDLE;
      ST_SKIP: if (!anyLow) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl            = '0;
    ctrl.cntClear   = (state != ST_WAIT);
    ctrl.cntStep    = (state == ST_WAIT);
    ctrl.fireAccess = (state == ST_WAIT) && anyLow && cntDone;
    ctrl.ackDrive   = (stateNext == ST_ACK);
  end

endmodule

// File: rtl/ackgen_top.sv
module ackgen_top
  import ackgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DELAY   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeAN,
  input  logic strobeBN,
  input  logic selIn,
  input  logic writeIn,
  output logic ackN,
  output logic localRd,
  output logic localWr
);

  localparam int CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY);

  ctrlStrobe_t ctrl;
  logic        anyLow;
  logic        cntDone;

  ackgen_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .anyLow  (anyLow),
    .cntDone (cntDone),
    .selIn   (selIn),
    .ctrl    (ctrl)
  );

  ackgen_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .ACK_DELAY   (ACK_DELAY),
    .CNT_W       (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobeAN (strobeAN),
    .strobeBN (strobeBN),
    .writeIn  (writeIn),
    .ctrl     (ctrl),
    .anyLow   (anyLow),
    .cntDone  (cntDone),
    .ackN     (ackN),
    .localRd  (localRd),
    .localWr  (localWr)
  );

endmodule

// File: rtl/ackgen_checker.sv
module ackgen_checker #(
  parameter int ACK_DELAY = 4
) (
  input logic clk,
  input logic rstN,
  input logic anyLow,
  input logic selIn,
  input logic ackN,
  input logic localRd,
  input logic localWr
);

  localparam int RUN_CAP = ACK_DELAY + 1;

  int unsigned lowRun;

  // consecutive cycles the synchronised strobes have been seen low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowRun <= 0;
    else if (!anyLow)          lowRun <= 0;
    else if (lowRun < RUN_CAP) lowRun <= lowRun + 1;
  end

  AST_IDLE_ACK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !$past(anyLow) |-> ackN); // R1

  AST_RELEASE_FAST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!ackN) && !$past(anyLow)) |-> ackN); // R4

  AST_MIN_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> (lowRun >= RUN_CAP)); // R3

  AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(selIn)); // R5

  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(anyLow)); // R8

  AST_PULSE_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (localRd || localWr) |-> $fell(ackN)); // R6

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({localRd, localWr})); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (localRd || localWr) |=> !(localRd || localWr)); // R7

endmodule

bind ackgen_top ackgen_checker #(.ACK_DELAY(ACK_DELAY)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .anyLow  (anyLow),
  .selIn   (selIn),
  .ackN    (ackN),
  .localRd (localRd),
  .localWr (localWr)
);

// File: tb/tb_ackgen_top.sv
`timescale 1ns/1ps
module tb_ackgen_top;

  logic clk = 1'b0;
  logic rstN;
  logic strobeAN, strobeBN, selIn, writeIn;
  logic ackN, localRd, localWr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ackgen_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .strobeAN (strobeAN),
    .strobeBN (strobeBN),
    .selIn    (selIn),
    .writeIn  (writeIn),
    .ackN     (ackN),
    .localRd  (localRd),
    .localWr  (localWr)
  );

  typedef struct packed {
    logic       aLow;
    logic       bLow;
    logic       sel;
    logic       wr;
    logic [7:0] len;
    logic [7:0] first;
    logic [7:0] rel;
  } vec_t;

  localparam int NV = 8;
  // first/rel: observation index of first ack-low cycle and of ack back high (0 = none)
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd10, 8'd7, 8'd13},
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd10, 8'd7, 8'd13},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'd12, 8'd7, 8'd15},
    '{1'b1, 1'b1, 1'b0, 8'd0 == 8'd0, 8'd10, 8'd0, 8'd0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd4,  8'd0, 8'd0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd5,  8'd7, 8'd8},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd20, 8'd7, 8'd23},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd1,  8'd0, 8'd0}
  };

  function automatic string tagOf(input int idx);
    case (idx)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R5";
      4, 5, 7: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input string tag);
    logic expAck;
    @(negedge clk);
    selIn    = v.sel;
    writeIn  = v.wr;
    strobeAN = ~v.aLow;
    strobeBN = ~v.bLow;
    for (int j = 1; j <= int'(v.len) + 4; j++) begin
      @(negedge clk);
      expAck = (v.first != 0) && (j >= int'(v.first)) && (j < int'(v.rel));
      check(tag, "ackN (R3/R4)", ackN, ~expAck);
      check("R6", "localRd", localRd, (v.first != 0) && (j == int'(v.first)) && !v.wr);
      check("R7", "localWr", localWr, (v.first != 0) && (j == int'(v.first)) && v.wr);
      if (j == int'(v.len)) begin
        strobeAN = 1'b1;
        strobeBN = 1'b1;
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", "idle ackN", ackN, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    strobeAN = 1'b1;
    strobeBN = 1'b1;
    selIn = 1'b0;
    writeIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "reset ackN", ackN, 1'b1);
    check("R9", "reset localRd", localRd, 1'b0);
    check("R9", "reset localWr", localWr, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "ackN after reset", ackN, 1'b1);

    for (int i = 0; i < NV; i++) runVec(VECS[i], tagOf(i));

    // R4: one strobe hands over to the other while the acknowledge is held
    selIn = 1'b1;
    writeIn = 1'b0;
    strobeAN = 1'b0;
    repeat (9) @(negedge clk);
    check("R4", "ack while A low", ackN, 1'b0);
    strobeBN = 1'b0;
    @(negedge clk);
    strobeAN = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check("R4", "ack held by B", ackN, 1'b0);
      check("R7", "no second pulse", localRd, 1'b0);
    end
    strobeBN = 1'b1;
    repeat (2) @(negedge clk);
    check("R4", "ack before release edge", ackN, 1'b0);
    @(negedge clk);
    check("R4", "ack released", ackN, 1'b1);

    // R9: reset during an acknowledged cycle
    repeat (3) @(negedge clk);
    strobeAN = 1'b0;
    repeat (8) @(negedge clk);
    check("R3", "ack before reset", ackN, 1'b0);
    rstN = 1'b0;
    #1;
    check("R9", "ackN in reset", ackN, 1'b1);
    check("R9", "localRd in reset", localRd, 1'b0);
    strobeAN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "ackN after mid reset", ackN, 1'b1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule